// File: doc/BRIEF.md
# Atomic-Write Signature Filter

Each core keeps a compact record of the word addresses it has written inside atomic sections. The record is a 256-bit Bloom filter. When a core takes a lock, it receives the previous holder's record with the lock message and merges it into its own. After that, any atomic load whose address may appear in the record has to drop its locally cached copy and fetch again before it reads. The record only holds stores that carry an atomic effect, so ordinary stores never cause self-invalidation.

The block also keeps one touched bit per tracked cache word. The first atomic load of a word in a critical section consults the filter and sets the bit. Later atomic loads of the same word skip the check. A load to a word the core holds in Registered state never self-invalidates, because that core already owns the current value. When the lock is released, the filter contents go out on the export port, and the filter and all touched bits are cleared.

Top module: `awsig_filter`

## Requirements
- R1: After a synchronous reset, the filter and all touched bits are empty and every output is 0. A query made right after reset reports a miss.
- R2: An insert takes place when `st_valid` and `st_atomic` are both 1. It sets filter bit h0 and filter bit h1 for `st_addr`. With `st_atomic` at 0 the store leaves the filter unchanged. For a 32-bit word address a, h0 is the XOR of its four bytes a[7:0], a[15:8], a[23:16] and a[31:24]. h1 is the XOR of those same four bytes after each is rotated left by 1, 2, 3 and 4 places respectively.
- R3: A query takes place when `ld_valid` and `ld_atomic` are both 1. One cycle later, `q_valid` is 1 and `q_hit` is 1 exactly when both h0 and h1 of `ld_addr` were set in the filter as it stood before that cycle's updates. A load with `ld_atomic` at 0 gives `q_valid` 0 and `q_hit` 0.
- R4: `q_inval` equals `q_hit` AND NOT `ld_registered` AND NOT the touched bit of the word. Both the Registered flag and the touched bit are taken as they were in the cycle of the query.
- R5: Each atomic load sets the touched bit at index `ld_addr[5:0]`, whether or not it hits. Non-atomic loads leave the touched bits unchanged. A release clears every touched bit. A load in the same cycle as a release still leaves its own bit set.
- R6: On `rel` high, `sig_out_valid` is 1 for exactly the next cycle, and `sig_out` carries the filter as it stood before that cycle. The filter is then cleared.
- R7: On `imp_valid` high, `imp_sig` is ORed into the filter in that cycle and becomes visible to queries from the next cycle on.
- R8: When events fall in the same cycle, the new filter is (the old filter, or zero on release) OR the imported signature OR the two inserted bits. Nothing in a cycle is lost apart from the old contents on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_atomic | input | 1 | Store carries an atomic effect |
| st_addr | input | 32 | Store word address |
| ld_valid | input | 1 | Load presented |
| ld_atomic | input | 1 | Load carries an atomic effect |
| ld_registered | input | 1 | Loaded word is held in Registered state |
| ld_addr | input | 32 | Load word address |
| imp_valid | input | 1 | Incoming lock message carries a signature |
| imp_sig | input | 256 | Signature received with the lock |
| rel | input | 1 | Lock release / critical-section end |
| q_valid | output | 1 | Query result valid |
| q_hit | output | 1 | Address may be in the filter |
| q_inval | output | 1 | Local copy must be self-invalidated |
| sig_out_valid | output | 1 | Export signature valid |
| sig_out | output | 256 | Signature to send with the lock |

## Verification
All results are registered, with exactly one cycle of delay. A query result, the invalidate decision and an export all appear on the clock edge after the request. Import and insert effects appear in the result of any query made one cycle or more later. The bench drives each stimulus on a falling edge and updates its behavioural model for that cycle. It lets one rising edge pass and compares every output at the next falling edge. This applies to same-cycle mixes of insert, import, release and query as well.

// File: rtl/awsig_pkg.sv
package awsig_pkg;
  localparam int unsigned SIG_BITS_DEF  = 256;
  localparam int unsigned ADDR_W_DEF    = 32;
  localparam int unsigned NUM_WORDS_DEF = 64;

  function automatic int unsigned clog2u(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx0,
  output logic [IDX_W-1:0]  idx1
);
  localparam int unsigned NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] plain [NCHUNK];
  logic [IDX_W-1:0] rot   [NCHUNK];

  assign padded = PAD_W'(addr);

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    localparam int unsigned R = (i + 1) % IDX_W;
    assign plain[i] = padded[i*IDX_W +: IDX_W];
    assign rot[i]   = IDX_W'((plain[i] << R) | (plain[i] >> (IDX_W - R)));
  end

  always_comb begin
    idx0 = '0;
    idx1 = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      idx0 = idx0 ^ plain[i];
      idx1 = idx1 ^ rot[i];
    end
  end
endmodule

// File: rtl/sig_store.sv
module sig_store #(
  parameter int unsigned SIG_BITS = 256,
  parameter int unsigned IDX_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                imp_en,
  input  logic [SIG_BITS-1:0] imp_sig,
  input  logic                ins_en,
  input  logic [IDX_W-1:0]    ins_idx0,
  input  logic [IDX_W-1:0]    ins_idx1,
  output logic [SIG_BITS-1:0] filt
);
  logic [SIG_BITS-1:0] base, merged, ins_mask, nxt;

  always_comb begin
    base     = clr ? '0 : filt;
    merged   = base | (imp_en ? imp_sig : '0);
    ins_mask = '0;
    if (ins_en) begin
      ins_mask[ins_idx0] = 1'b1;
      ins_mask[ins_idx1] = 1'b1;
    end
    nxt = merged | ins_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) filt <= '0;
    else     filt <= nxt;
  end

  // R6: release with nothing merged leaves an empty filter
  assert_clear_on_release_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !imp_en && !ins_en) |=> (filt == '0));
  // R2: both hashed bits present after an insert
  assert_insert_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> (filt[$past(ins_idx0)] && filt[$past(ins_idx1)]));
  // R7: imported bits all present next cycle
  assert_import_or_R7: assert property (@(posedge clk) disable iff (rst)
    imp_en |=> ((filt & $past(imp_sig)) == $past(imp_sig)));
  // R8: without release no bit is ever lost
  assert_monotone_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((filt & $past(filt)) == $past(filt)));
endmodule

// File: rtl/touch_track.sv
module touch_track #(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned TW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set_en,
  input  logic [TW-1:0] set_idx,
  output logic          look_hit
);
  logic [NUM_WORDS-1:0] touched, nxt;

  assign look_hit = touched[set_idx];

  always_comb begin
    nxt = clr ? '0 : touched;
    if (set_en) nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) touched <= '0;
    else     touched <= nxt;
  end

  // R5: the loaded word is marked next cycle
  assert_touch_set_R5: assert property (@(posedge clk) disable iff (rst)
    set_en |=> touched[$past(set_idx)]);
  // R5: release without load leaves nothing marked
  assert_touch_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_en) |=> (touched == '0));
endmodule

// File: rtl/awsig_filter.sv
module awsig_filter
  import awsig_pkg::*;
#(
  parameter int unsigned SIG_BITS  = SIG_BITS_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned NUM_WORDS = NUM_WORDS_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                st_valid,
  input  logic                st_atomic,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                ld_valid,
  input  logic                ld_atomic,
  input  logic                ld_registered,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic                imp_valid,
  input  logic [SIG_BITS-1:0] imp_sig,
  input  logic                rel,
  output logic                q_valid,
  output logic                q_hit,
  output logic                q_inval,
  output logic                sig_out_valid,
  output logic [SIG_BITS-1:0] sig_out
);
  localparam int unsigned IDX_W = clog2u(SIG_BITS);
  localparam int unsigned TW    = clog2u(NUM_WORDS);

  logic [IDX_W-1:0]    s_h0, s_h1, l_h0, l_h1;
  logic [SIG_BITS-1:0] filt;
  logic                ins_en, qry_en, was_touched, raw_hit;

  assign ins_en = st_valid && st_atomic;
  assign qry_en = ld_valid && ld_atomic;

  sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_st_hash (
    .addr(st_addr), .idx0(s_h0), .idx1(s_h1));
  sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ld_hash (
    .addr(ld_addr), .idx0(l_h0), .idx1(l_h1));

  sig_store #(.SIG_BITS(SIG_BITS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .clr(rel), .imp_en(imp_valid), .imp_sig(imp_sig),
    .ins_en(ins_en), .ins_idx0(s_h0), .ins_idx1(s_h1), .filt(filt));

  touch_track #(.NUM_WORDS(NUM_WORDS), .TW(TW)) u_touch (
    .clk(clk), .rst(rst), .clr(rel), .set_en(qry_en),
    .set_idx(ld_addr[TW-1:0]), .look_hit(was_touched));

  assign raw_hit = filt[l_h0] && filt[l_h1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid       <= 1'b0;
      q_hit         <= 1'b0;
      q_inval       <= 1'b0;
      sig_out_valid <= 1'b0;
      sig_out       <= '0;
    end else begin
      q_valid       <= qry_en;
      q_hit         <= qry_en && raw_hit;
      q_inval       <= qry_en && raw_hit && !ld_registered && !was_touched;
      sig_out_valid <= rel;
      if (rel) sig_out <= filt;
    end
  end

  // R3: a result follows each atomic load and nothing else
  assert_result_follows_R3: assert property (@(posedge clk) disable iff (rst)
    qry_en |=> q_valid);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !qry_en |=> (!q_valid && !q_hit));
  // R4: invalidate only on a hit, never for a Registered word
  assert_inval_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    q_inval |-> q_hit);
  assert_registered_safe_R4: assert property (@(posedge clk) disable iff (rst)
    (qry_en && ld_registered) |=> !q_inval);
  // R6: export lasts one cycle after each release
  assert_export_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rel |=> sig_out_valid);
  assert_export_only_R6: assert property (@(posedge clk) disable iff (rst)
    !rel |=> !sig_out_valid);
endmodule

// File: tb/awsig_filter_bench.sv
module awsig_filter_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         st_valid, st_atomic, ld_valid, ld_atomic, ld_registered;
  logic [31:0]  st_addr, ld_addr;
  logic         imp_valid, rel;
  logic [255:0] imp_sig;
  logic         q_valid, q_hit, q_inval, sig_out_valid;
  logic [255:0] sig_out;

  int checks = 0;
  int failures = 0;

  bit [255:0] m_filt;
  bit [63:0]  m_touch;
  bit         e_qv, e_hit, e_inv, e_sv;
  bit [255:0] e_sig;

  always #5 clk = ~clk;

  awsig_filter u_awsig_filter (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_atomic(st_atomic),
    .st_addr(st_addr), .ld_valid(ld_valid), .ld_atomic(ld_atomic),
    .ld_registered(ld_registered), .ld_addr(ld_addr), .imp_valid(imp_valid),
    .imp_sig(imp_sig), .rel(rel), .q_valid(q_valid), .q_hit(q_hit),
    .q_inval(q_inval), .sig_out_valid(sig_out_valid), .sig_out(sig_out));

  function automatic bit [7:0] rl(input bit [7:0] v, input int n);
    bit [7:0] r;
    r = v;
    for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic bit [7:0] hA(input bit [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
  endfunction

  function automatic bit [7:0] hB(input bit [31:0] a);
    return rl(a[7:0], 1) ^ rl(a[15:8], 2) ^ rl(a[23:16], 3) ^ rl(a[31:24], 4);
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    st_valid = 0; st_atomic = 0; st_addr = '0;
    ld_valid = 0; ld_atomic = 0; ld_registered = 0; ld_addr = '0;
    imp_valid = 0; imp_sig = '0; rel = 0;
  endtask

  // Model one cycle from the inputs currently driven, then compare after the edge.
  task automatic step();
    bit [255:0] nf;
    bit [63:0]  nt;
    bit         qry, hit;
    qry   = ld_valid && ld_atomic;
    hit   = m_filt[hA(ld_addr)] && m_filt[hB(ld_addr)];
    e_qv  = qry;
    e_hit = qry && hit;
    e_inv = qry && hit && !ld_registered && !m_touch[ld_addr[5:0]];
    e_sv  = rel;
    if (rel) e_sig = m_filt;
    nf = rel ? '0 : m_filt;
    if (imp_valid) nf = nf | imp_sig;
    if (st_valid && st_atomic) begin
      nf[hA(st_addr)] = 1'b1;
      nf[hB(st_addr)] = 1'b1;
    end
    nt = rel ? '0 : m_touch;
    if (qry) nt[ld_addr[5:0]] = 1'b1;
    m_filt  = nf;
    m_touch = nt;
    @(posedge clk);
    @(negedge clk);
    chk("R3 q_valid", 256'(q_valid), 256'(e_qv));
    chk("R3 q_hit", 256'(q_hit), 256'(e_hit));
    chk("R4 q_inval", 256'(q_inval), 256'(e_inv));
    chk("R6 sig_out_valid", 256'(sig_out_valid), 256'(e_sv));
    if (e_sv) chk("R6 sig_out", sig_out, e_sig);
  endtask

  task automatic do_store(input bit [31:0] a, input bit atomic);
    idle_inputs(); st_valid = 1; st_atomic = atomic; st_addr = a; step();
  endtask

  task automatic do_load(input bit [31:0] a, input bit atomic, input bit regd);
    idle_inputs(); ld_valid = 1; ld_atomic = atomic; ld_registered = regd; ld_addr = a; step();
  endtask

  task automatic do_rel();
    idle_inputs(); rel = 1; step();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    m_filt = '0; m_touch = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs idle after reset
    chk("R1 q_valid reset", 256'(q_valid), 256'(0));
    chk("R1 q_inval reset", 256'(q_inval), 256'(0));
    chk("R1 sig_out_valid reset", 256'(sig_out_valid), 256'(0));
    chk("R1 sig_out reset", sig_out, '0);
    do_load(32'h1234_5678, 1, 0);          // R1: empty filter misses
    do_rel();                              // R1: exported filter is empty

    // R2: ordinary store ignored, atomic store inserts
    do_store(32'h0000_1040, 0);
    do_load(32'h0000_1040, 1, 0);          // miss expected
    do_rel();
    do_store(32'h0000_1040, 1);
    do_load(32'h0000_1040, 1, 0);          // R4: first load hits and invalidates
    do_load(32'h0000_1040, 1, 0);          // R5: touched, no invalidate
    do_load(32'h0000_1040, 0, 0);          // R3: non-atomic gives no result
    do_rel();                              // R6: export then clear
    do_load(32'h0000_1040, 1, 0);          // R6: cleared -> miss

    // R4: registered word never invalidates
    do_store(32'hAB00_0003, 1);
    do_load(32'hAB00_0003, 1, 1);
    do_rel();

    // R7: import ORed in one cycle
    idle_inputs(); imp_valid = 1;
    imp_sig = '0; imp_sig[hA(32'h0BAD_F00D)] = 1; imp_sig[hB(32'h0BAD_F00D)] = 1;
    step();
    do_load(32'h0BAD_F00D, 1, 0);

    // R8: release, import and insert in one cycle
    idle_inputs(); rel = 1; imp_valid = 1; imp_sig = 256'h1 << 77;
    st_valid = 1; st_atomic = 1; st_addr = 32'h0000_0055;
    ld_valid = 1; ld_atomic = 1; ld_addr = 32'h0BAD_F00D;
    step();
    do_load(32'h0000_0055, 1, 0);
    do_load(32'h0BAD_F00D, 1, 0);          // R5: touched kept through release
    do_rel();

    // Mixed random traffic on a small address pool
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      st_valid = $urandom_range(0, 1); st_atomic = $urandom_range(0, 1);
      st_addr = 32'h100 + $urandom_range(0, 20);
      ld_valid = $urandom_range(0, 1); ld_atomic = $urandom_range(0, 3) != 0;
      ld_registered = $urandom_range(0, 3) == 0;
      ld_addr = 32'h100 + $urandom_range(0, 24);
      imp_valid = $urandom_range(0, 15) == 0;
      imp_sig = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom}
                & {8{$urandom}};
      rel = $urandom_range(0, 19) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule